// File: doc/BRIEF.md
# Ping-Pong Sample Buffer Writer

This block takes a stream of converted samples, each marked by a one-cycle valid strobe, and writes them into memory with no processor help. Memory holds two equal buffers, ping and pong. The block fills one of them, one sample per strobe. When that buffer holds its last sample, filling moves to the other buffer and the full one is given to the consumer.

When a buffer is given to the consumer, the block raises a one-cycle interrupt and reports which buffer may now be read. It keeps a readable flag set until the consumer pulses its release input. If the next buffer fills before that release arrives, an overrun flag is set. Filling goes on without stopping, so the input stream is never stalled.

The memory address has the buffer-select bit on top of a sample index. The buffer length is a parameter and need not be a power of two.

Top module: `ppw_buffer_writer`

## Requirements
- R1: After reset, `mem_we`, `full_irq`, `rd_ok` and `overrun` are all 0.
- R2: Every clock cycle with `smp_vld` high gives exactly one memory write in the following cycle: `mem_we` is 1 and `mem_wdata` equals the sample. A cycle without `smp_vld` gives no write in the following cycle.
- R3: `mem_addr` is {bank, index}. The bank bit is bit IDX_W, where IDX_W = clog2(BUF_LEN), and 0 means ping. The index is in bits IDX_W-1:0 and counts 0, 1, ..., BUF_LEN-1 within a buffer.
- R4: The first buffer filled after reset is ping. After BUF_LEN writes, filling moves to the other bank, and the banks alternate after that.
- R5: `full_irq` is a one-cycle pulse. It appears in the cycle right after the write of the last sample (index BUF_LEN-1) of a buffer.
- R6: In the cycle that `full_irq` is high, `rd_bank` names the buffer that just completed and `rd_ok` is 1.
- R7: While `rd_ok` is 1, no write goes to the bank named by `rd_bank`.
- R8: A `cons_release` pulse clears `rd_ok` and `overrun` in the next cycle. This holds unless a buffer completes at that same clock edge.
- R9: If a buffer completes while `rd_ok` is still 1 and no release comes at that edge, `overrun` goes to 1. It stays 1 until a release. Filling goes on into the other bank.
- R10: Idle cycles between samples do not move the index or the bank.
- R11: If a release comes at the same edge at which a buffer completes, the new buffer is handed over: `rd_ok` stays 1 and `overrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | A new sample is present this cycle |
| smp_data | input | SAMPLE_W | Sample value |
| cons_release | input | 1 | Consumer has finished with the buffer it holds |
| mem_addr | output | IDX_W+1 | Write address {bank, index} |
| mem_wdata | output | SAMPLE_W | Write data |
| mem_we | output | 1 | Write enable |
| full_irq | output | 1 | One-cycle pulse: a buffer has been handed over |
| rd_bank | output | 1 | Buffer the consumer may read (0 ping, 1 pong) |
| rd_ok | output | 1 | The buffer named by rd_bank is owned by the consumer |
| overrun | output | 1 | A buffer completed before the previous one was released |

## Verification
If the sample index or the bank bit goes wrong inside the block, the next write shows it at once: `mem_addr` is off in the cycle after the strobe. A wrong end-of-buffer decision shows up within one buffer length: `full_irq` either misses its cycle after the write at index BUF_LEN-1 or arrives somewhere else. Errors in the handoff state show one cycle after the edge that caused them, on `rd_ok` or `overrun`. They show up sooner if a write lands in the bank the consumer holds.

// File: rtl/ppw_pkg.sv
package ppw_pkg;
   typedef enum logic {
      BANK_PING = 1'b0,
      BANK_PONG = 1'b1
   } bank_e;

   function automatic bank_e bank_flip(bank_e b);
      return (b == BANK_PING) ? BANK_PONG : BANK_PING;
   endfunction
endpackage

// File: rtl/ppw_index_ctr.sv
module ppw_index_ctr
   import ppw_pkg::*;
#(
   parameter int BUF_LEN = 32,
   localparam int IDX_W  = $clog2(BUF_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] idx,
   output bank_e            bank,
   output logic             at_last
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BUF_LEN - 1);
   localparam bit POW2 = ((1 << IDX_W) == BUF_LEN);

   logic [IDX_W-1:0] idx_nxt;

   generate
      if (POW2) begin : g_pow2
         // The index wraps on its own at the top of the range
         assign at_last = &idx;
         assign idx_nxt = idx + 1'b1;
      end else begin : g_nonpow2
         assign at_last = (idx == LAST_IDX);
         assign idx_nxt = at_last ? '0 : idx + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx  <= '0;
         bank <= BANK_PING;
      end else if (adv) begin
         idx <= idx_nxt;
         if (at_last) bank <= bank_flip(bank);
      end
   end
endmodule

// File: rtl/ppw_write_stage.sv
module ppw_write_stage
   import ppw_pkg::*;
#(
   parameter int SAMPLE_W = 14,
   parameter int BUF_LEN  = 32,
   localparam int IDX_W   = $clog2(BUF_LEN),
   localparam int ADDR_W  = IDX_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vld,
   input  logic [SAMPLE_W-1:0] data,
   input  logic [IDX_W-1:0]    idx,
   input  bank_e               bank,
   input  logic                at_last,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [SAMPLE_W-1:0] wr_data,
   output logic                wr_en,
   output logic                wr_last
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_last <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_en   <= vld;
         wr_last <= vld & at_last;
         if (vld) begin
            wr_addr <= {bank, idx};
            wr_data <= data;
         end
      end
   end
endmodule

// File: rtl/ppw_handoff.sv
module ppw_handoff
   import ppw_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  done,
   input  bank_e done_bank,
   input  logic  release_i,
   output logic  irq,
   output bank_e owned_bank,
   output logic  owned,
   output logic  ovr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq        <= 1'b0;
         owned_bank <= BANK_PONG;
         owned      <= 1'b0;
         ovr        <= 1'b0;
      end else begin
         irq <= done;
         if (done) begin
            owned_bank <= done_bank;
            owned      <= 1'b1;
            if (release_i)  ovr <= 1'b0;
            else if (owned) ovr <= 1'b1;
         end else if (release_i) begin
            owned <= 1'b0;
            ovr   <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ppw_buffer_writer.sv
module ppw_buffer_writer
   import ppw_pkg::*;
#(
   parameter int SAMPLE_W = 14,
   parameter int BUF_LEN  = 32,
   localparam int IDX_W   = $clog2(BUF_LEN),
   localparam int ADDR_W  = IDX_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_vld,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                cons_release,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [SAMPLE_W-1:0] mem_wdata,
   output logic                mem_we,
   output logic                full_irq,
   output logic                rd_bank,
   output logic                rd_ok,
   output logic                overrun
);
   generate
      if (BUF_LEN < 2) begin : g_bad_len
         $error("ppw_buffer_writer: BUF_LEN must be at least 2");
      end
      if (SAMPLE_W < 1) begin : g_bad_w
         $error("ppw_buffer_writer: SAMPLE_W must be positive");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   bank_e            fill_bank;
   logic             at_last;
   logic             wr_last;
   bank_e            owned_bank;

   ppw_index_ctr #(.BUF_LEN(BUF_LEN)) u_idx (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (smp_vld),
      .idx     (idx),
      .bank    (fill_bank),
      .at_last (at_last)
   );

   ppw_write_stage #(.SAMPLE_W(SAMPLE_W), .BUF_LEN(BUF_LEN)) u_wr (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld     (smp_vld),
      .data    (smp_data),
      .idx     (idx),
      .bank    (fill_bank),
      .at_last (at_last),
      .wr_addr (mem_addr),
      .wr_data (mem_wdata),
      .wr_en   (mem_we),
      .wr_last (wr_last)
   );

   ppw_handoff u_ho (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (wr_last),
      .done_bank  (bank_e'(mem_addr[ADDR_W-1])),
      .release_i  (cons_release),
      .irq        (full_irq),
      .owned_bank (owned_bank),
      .owned      (rd_ok),
      .ovr        (overrun)
   );

   assign rd_bank = owned_bank;
endmodule

// File: rtl/ppw_chk.sv
module ppw_chk #(
   parameter int SAMPLE_W = 14,
   parameter int BUF_LEN  = 32,
   localparam int IDX_W   = $clog2(BUF_LEN),
   localparam int ADDR_W  = IDX_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_vld,
   input logic              cons_release,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we,
   input logic              full_irq,
   input logic              rd_bank,
   input logic              rd_ok,
   input logic              overrun
);
   // R2
   write_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |=> mem_we);
   // R2
   no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> !mem_we);
   // R3
   index_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (int'(mem_addr[IDX_W-1:0]) < BUF_LEN));
   // R5
   irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_irq |=> !full_irq);
   // R6
   irq_grants_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_irq |-> rd_ok);
   // R7
   no_write_to_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && rd_ok) |-> (mem_addr[ADDR_W-1] != rd_bank));
   // R8
   release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cons_release) && !full_irq) |-> (!rd_ok && !overrun));
   // R9
   overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_irq && $past(rd_ok) && !$past(cons_release)) |-> overrun);
endmodule

bind ppw_buffer_writer ppw_chk #(.SAMPLE_W(SAMPLE_W), .BUF_LEN(BUF_LEN)) u_chk (.*);

// File: tb/ppw_buffer_writer_tb.sv
`timescale 1ns/1ps
module ppw_buffer_writer_tb;
   localparam int SW   = 14;
   localparam int LEN  = 8;
   localparam int IW   = $clog2(LEN);
   localparam int AW   = IW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_vld = 1'b0;
   logic [SW-1:0] smp_data = '0;
   logic          cons_release = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [SW-1:0] mem_wdata;
   logic          mem_we, full_irq, rd_bank, rd_ok, overrun;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   int exp_idx = 0;
   int exp_bank = 0;
   int exp_rdbank = 0;
   bit exp_rdok = 1'b0;
   bit exp_ovr = 1'b0;

   always #2 clk = ~clk;

   ppw_buffer_writer #(.SAMPLE_W(SW), .BUF_LEN(LEN)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .cons_release(cons_release), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .full_irq(full_irq), .rd_bank(rd_bank), .rd_ok(rd_ok),
      .overrun(overrun)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_state(string req);
      chk(req, "rd_ok", int'(rd_ok), int'(exp_rdok));
      chk(req, "overrun", int'(overrun), int'(exp_ovr));
      if (exp_rdok) chk(req, "rd_bank", int'(rd_bank), exp_rdbank);
   endtask

   // One sample over two cycles; rel2 drives a release in the second cycle
   task automatic send_sample(int value, bit rel2, string req);
      bit last;
      last = (exp_idx == LEN - 1);
      smp_vld  = 1'b1;
      smp_data = SW'(value);
      @(negedge clk);
      smp_vld = 1'b0;
      cons_release = rel2;
      chk("R2", "mem_we", int'(mem_we), 1);
      chk("R2", "mem_wdata", int'(mem_wdata), value & ((1 << SW) - 1));
      chk("R3", "mem_addr", int'(mem_addr), exp_bank * (1 << IW) + exp_idx);
      @(negedge clk);
      cons_release = 1'b0;
      if (last) begin
         if (rel2) exp_ovr = 1'b0;
         else if (exp_rdok) exp_ovr = 1'b1;
         exp_rdok   = 1'b1;
         exp_rdbank = exp_bank;
         exp_bank   = 1 - exp_bank;
         exp_idx    = 0;
      end else begin
         exp_idx++;
         if (rel2) begin
            exp_rdok = 1'b0;
            exp_ovr  = 1'b0;
         end
      end
      chk("R5", "full_irq", int'(full_irq), int'(last));
      chk(req, "mem_we idle", int'(mem_we), 0);
      chk_state(req);
   endtask

   task automatic fill_buffer(int base, bit rel_last, string req);
      for (int i = 0; i < LEN; i++)
         send_sample(base + i, rel_last && (i == LEN - 1), req);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "mem_we", int'(mem_we), 0);
      chk("R1", "full_irq", int'(full_irq), 0);
      chk("R1", "rd_ok", int'(rd_ok), 0);
      chk("R1", "overrun", int'(overrun), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_first_fill_ping;
      fill_buffer(100, 1'b0, "R4");
      chk("R6", "rd_bank ping", int'(rd_bank), 0);
      chk("R6", "rd_ok after fill", int'(rd_ok), 1);
   endtask

   task automatic t_gaps;
      for (int i = 0; i < 3; i++) begin
         send_sample(500 + i, 1'b0, "R10");
         repeat (4) begin
            @(negedge clk);
            chk("R10", "no write in gap", int'(mem_we), 0);
            chk("R10", "no irq in gap", int'(full_irq), 0);
         end
      end
      for (int i = 3; i < LEN; i++) send_sample(500 + i, 1'b0, "R10");
   endtask

   task automatic t_release;
      cons_release = 1'b1;
      @(negedge clk);
      cons_release = 1'b0;
      exp_rdok = 1'b0;
      exp_ovr  = 1'b0;
      chk("R8", "rd_ok cleared", int'(rd_ok), 0);
      chk("R8", "overrun cleared", int'(overrun), 0);
   endtask

   task automatic t_overrun;
      fill_buffer(700, 1'b0, "R9");
      chk("R9", "overrun set", int'(overrun), 1);
      send_sample(900, 1'b0, "R9");
      chk("R9", "overrun held", int'(overrun), 1);
      for (int i = 1; i < LEN; i++) send_sample(900 + i, 1'b0, "R9");
   endtask

   task automatic t_simultaneous;
      fill_buffer(1200, 1'b0, "R4");
      fill_buffer(1300, 1'b1, "R11");
      chk("R11", "rd_ok kept", int'(rd_ok), 1);
      chk("R11", "no overrun", int'(overrun), 0);
   endtask

   task automatic t_stream;
      int writes = 0;
      int irqs = 0;
      smp_vld = 1'b1;
      for (int c = 0; c < 2 * LEN + 4; c++) begin
         @(negedge clk);
         if (c == 2 * LEN - 1) smp_vld = 1'b0;
         smp_data = smp_data + 1'b1;
         if (mem_we) writes++;
         if (full_irq) irqs++;
         if (mem_we && rd_ok)
            chk("R7", "write avoids owned bank", int'(mem_addr[AW-1] != rd_bank), 1);
      end
      chk("R2", "stream writes", writes, 2 * LEN);
      chk("R5", "stream irqs", irqs, 2);
      exp_rdok   = 1'b1;
      exp_ovr    = 1'b1;
      exp_rdbank = 1 - exp_bank;
      chk_state("R9");
   endtask

   initial begin
      #(4 * 100000);
      if (!done_flag) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_first_fill_ping();
      t_release();
      t_gaps();
      chk("R4", "second buffer is pong", int'(rd_bank), 1);
      t_overrun();
      t_release();
      t_simultaneous();
      t_release();
      t_stream();
      t_release();
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule